// File: doc/BRIEF.md
# Color Palette Index/Data Port

This block gives a CPU byte-wide access to two banks of color palette memory: a background bank and an object bank. Each bank holds 32 colors of 16 bits. The CPU reaches a bank through a pair of registers. A pointer register picks one byte of the bank and holds a flag that turns on automatic stepping. A data register reads or writes the byte that the pointer selects. Each bank has its own pointer, its own flag and its own data register.

The CPU side uses a single write strobe and a 2-bit register select. Reads are combinational from the current state, so the data register always shows the byte at the current pointer. This holds right after the pointer is rewritten and right after a data write. The renderer has a separate read port that returns a full 16-bit color word per request. It addresses the background words at 0..31 and the object words at 32..63.

Top module: `pal_port`

## Requirements
- R1: After reset, both pointers are 0, both auto-step flags are clear and every palette word reads as 0x0000. A pointer register then reads back as 0x40.
- R2: A pointer register write takes bits [5:0] as the byte pointer and bit 7 as the auto-step flag. Reading a pointer register returns {flag, 1, pointer}, so bit 6 always reads as 1.
- R3: A data register write stores the byte in word pointer>>1 of the selected bank. Pointer bit 0 picks the low byte (0) or the high byte (1), and the other byte of that word is left unchanged.
- R4: The object bank occupies renderer word addresses 32..63 and the background bank occupies 0..31. Object word n is therefore read at address 32+n.
- R5: In the cycle after a pointer write, the data register of that bank reads the byte at the new pointer.
- R6: A data register write with the auto-step flag set advances that bank's pointer by one. The pointer wraps from 63 to 0.
- R7: A data register write with the auto-step flag clear leaves the pointer unchanged, so a second write overwrites the same byte.
- R8: Reading any register, which means selecting it with the write strobe low, changes neither a pointer, a flag nor palette contents.
- R9: Writes to one bank's registers leave the other bank's pointer, flag and palette words unchanged.
- R10: The renderer port returns the word at ren_addr_i one clock after the address is presented. A write in that same cycle is not yet visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_we_i | input | 1 | Write strobe for the selected register |
| cpu_sel_i | input | 2 | Register select: 0 bg pointer, 1 bg data, 2 obj pointer, 3 obj data |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data of the selected register (combinational) |
| ren_addr_i | input | 6 | Renderer word address (bg 0..31, obj 32..63) |
| ren_data_o | output | 16 | Renderer word, registered |

## Verification
The CPU read path is combinational on the register state. A pointer write, a data write or an auto-step therefore shows up on cpu_rdata_o in the cycle after the strobe. The renderer word comes out exactly one clock after its address. The bench drives inputs on the falling edge and compares both outputs a short time later against a behavioural model. The model advances only at the rising edge, and it captures the renderer's expected word before it applies that cycle's write, which reproduces the one-cycle latency and the rule that a write is not yet visible on the renderer port in its own cycle. Every cycle of every scenario is compared this way, including the pointer wrap at 63 and back-to-back writes with the flag clear.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // sel[1] = bank (0 bg, 1 obj), sel[0] = data (1) / pointer (0)
  typedef enum logic [1:0] {
    SEL_BG_PTR   = 2'b00,
    SEL_BG_DATA  = 2'b01,
    SEL_OBJ_PTR  = 2'b10,
    SEL_OBJ_DATA = 2'b11
  } pal_sel_e;

  localparam int unsigned NBANKS    = 2;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned AUTO_BIT  = 7;
  localparam int unsigned FIXED_BIT = 6;
endpackage

// File: rtl/pal_ptr_reg.sv
module pal_ptr_reg #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic             data_we_i,
  input  logic [7:0]       wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             auto_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             auto_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
    end else if (ptr_we_i) begin
      ptr_q  <= wdata_i[PTR_W-1:0];
      auto_q <= wdata_i[pal_pkg::AUTO_BIT];
    end else if (data_we_i && auto_q) begin
      ptr_q  <= ptr_q + 1'b1; // natural wrap at 2**PTR_W
    end
  end

  assign ptr_o  = ptr_q;
  assign auto_o = auto_q;
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic              cpu_hi_i,
  input  logic [7:0]        wbyte_i,
  output logic [7:0]        rbyte_o,
  input  logic [AW-1:0]     ren_addr_i,
  output logic [WORD_W-1:0] ren_data_o
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WORD_W-1:0] cpu_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      if (cpu_hi_i) mem_q[cpu_addr_i][15:8] <= wbyte_i;
      else          mem_q[cpu_addr_i][7:0]  <= wbyte_i;
    end
  end

  assign cpu_word = mem_q[cpu_addr_i];
  assign rbyte_o  = cpu_hi_i ? cpu_word[15:8] : cpu_word[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ren_data_o <= '0;
    else         ren_data_o <= mem_q[ren_addr_i];
  end
endmodule

// File: rtl/pal_port.sv
module pal_port #(
  parameter int unsigned BANK_WORDS = 32,
  localparam int unsigned PTR_W     = $clog2(BANK_WORDS * 2),
  localparam int unsigned TOTAL_W   = BANK_WORDS * pal_pkg::NBANKS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_we_i,
  input  logic [1:0]       cpu_sel_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  input  logic [PTR_W-1:0] ren_addr_i,
  output logic [15:0]      ren_data_o
);
  logic [pal_pkg::NBANKS-1:0][PTR_W-1:0] idx_w;
  logic [pal_pkg::NBANKS-1:0]            inc_w;

  logic             bank;
  logic [PTR_W-1:0] cur_ptr;
  logic [PTR_W-1:0] word_addr;
  logic [7:0]       data_byte;
  logic [7:0]       ptr_byte;

  for (genvar s = 0; s < pal_pkg::NBANKS; s++) begin : g_bank
    pal_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ptr_we_i (cpu_we_i && cpu_sel_i == {s[0], 1'b0}),
      .data_we_i(cpu_we_i && cpu_sel_i == {s[0], 1'b1}),
      .wdata_i  (cpu_wdata_i),
      .ptr_o    (idx_w[s]),
      .auto_o   (inc_w[s])
    );
  end

  assign bank      = cpu_sel_i[1];
  assign cur_ptr   = idx_w[bank];
  assign word_addr = {bank, cur_ptr[PTR_W-1:1]};

  pal_store #(.WORDS(TOTAL_W), .WORD_W(16)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cpu_we_i && cpu_sel_i[0]),
    .cpu_addr_i(word_addr),
    .cpu_hi_i  (cur_ptr[0]),
    .wbyte_i   (cpu_wdata_i),
    .rbyte_o   (data_byte),
    .ren_addr_i(ren_addr_i),
    .ren_data_o(ren_data_o)
  );

  always_comb begin
    ptr_byte                      = '0;
    ptr_byte[PTR_W-1:0]           = cur_ptr;
    ptr_byte[pal_pkg::FIXED_BIT]  = 1'b1;
    ptr_byte[pal_pkg::AUTO_BIT]   = inc_w[bank];
  end

  assign cpu_rdata_o = cpu_sel_i[0] ? data_byte : ptr_byte;
endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
  parameter int unsigned PTR_W = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cpu_we_i,
  input logic [1:0]             cpu_sel_i,
  input logic [7:0]             cpu_wdata_i,
  input logic [7:0]             cpu_rdata_o,
  input logic [1:0][PTR_W-1:0]  idx_w,
  input logic [1:0]             inc_w
);
  for (genvar s = 0; s < 2; s++) begin : g_chk
    p_ptr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_we_i && cpu_sel_i == {s[0], 1'b0} |=>
        idx_w[s] == $past(cpu_wdata_i[PTR_W-1:0]) && inc_w[s] == $past(cpu_wdata_i[7]));

    p_auto_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_we_i && cpu_sel_i == {s[0], 1'b1} && inc_w[s] |=>
        idx_w[s] == PTR_W'($past(idx_w[s]) + 1'b1));

    p_no_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_we_i && cpu_sel_i == {s[0], 1'b1} && !inc_w[s] |=> $stable(idx_w[s]));

    p_other_bank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_we_i && cpu_sel_i[1] != s[0] |=> $stable(idx_w[s]) && $stable(inc_w[s]));
  end

  p_read_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i |=> $stable(idx_w) && $stable(inc_w));

  p_fixed_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_sel_i[0] |-> cpu_rdata_o[6]);
endmodule

bind pal_port pal_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_we_i   (cpu_we_i),
  .cpu_sel_i  (cpu_sel_i),
  .cpu_wdata_i(cpu_wdata_i),
  .cpu_rdata_o(cpu_rdata_o),
  .idx_w      (idx_w),
  .inc_w      (inc_w)
);

// File: tb/tb_pal_port.sv
`timescale 1ns/1ps
module tb_pal_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [5:0]  raddr = 6'd0;
  logic [15:0] rword;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  int ref_pal [64];
  int ref_ptr [2];
  int ref_auto[2];
  int exp_ren = 0;

  always #2.5 clk = ~clk;

  pal_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_sel_i(sel),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .ren_addr_i(raddr), .ren_data_o(rword)
  );

  function automatic int exp_cpu(int s);
    int b = s / 2;
    int w = b * 32 + ref_ptr[b] / 2;
    if (s % 2 == 0) return ref_auto[b] * 128 + 64 + ref_ptr[b];
    return (ref_ptr[b] % 2) ? (ref_pal[w] / 256) % 256 : ref_pal[w] % 256;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit w, int s, int d, int ra, string tag);
    @(negedge clk);
    we = w; sel = 2'(s); wdata = 8'(d); raddr = 6'(ra);
    #1;
    check(tag, int'(rdata), exp_cpu(s), "cpu read");
    check(tag, int'(rword), exp_ren, "renderer word");
    @(posedge clk);
    exp_ren = ref_pal[ra];
    if (w) begin
      int b = s / 2;
      if (s % 2 == 0) begin
        ref_ptr[b] = d % 64;
        ref_auto[b] = d / 128;
      end else begin
        int wi = b * 32 + ref_ptr[b] / 2;
        if (ref_ptr[b] % 2) ref_pal[wi] = (d % 256) * 256 + ref_pal[wi] % 256;
        else                ref_pal[wi] = (ref_pal[wi] / 256) * 256 + d % 256;
        if (ref_auto[b] != 0) ref_ptr[b] = (ref_ptr[b] + 1) % 64;
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_pal[i] = 0;
    for (int b = 0; b < 2; b++) begin ref_ptr[b] = 0; ref_auto[b] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state on all four registers and renderer words
    for (int s = 0; s < 4; s++) step(0, s, 0, s * 20, "R1");
    // R2 R6 R3: auto-step fill of background bank, wraps 63 -> 0
    step(1, 0, 8'h80, 0, "R2");
    step(0, 0, 0, 0, "R2");
    for (int i = 0; i < 64; i++) step(1, 1, (i * 37 + 5) % 256, i % 32, "R6");
    step(0, 0, 0, 0, "R6");
    // R4 R9: object bank writes, background untouched
    step(1, 2, 8'h85, 3, "R2");
    for (int i = 0; i < 10; i++) step(1, 3, (i * 11 + 200) % 256, 32 + i, "R4");
    for (int i = 0; i < 8; i++) step(0, i % 4, 0, 32 + i, "R9");
    step(0, 0, 0, 2, "R9");
    // R7: flag clear, same byte rewritten
    step(1, 0, 8'h07, 3, "R7");
    step(1, 1, 8'h5A, 3, "R7");
    step(1, 1, 8'hC3, 3, "R7");
    step(0, 1, 0, 3, "R7");
    // R8: repeated reads leave state alone
    for (int i = 0; i < 6; i++) step(0, i % 2 ? 3 : 1, 8'hFF, 3, "R8");
    // R5: pointer rewrite then immediate data read
    step(1, 0, 8'h12, 9, "R5");
    step(0, 1, 0, 9, "R5");
    step(1, 2, 8'h01, 32, "R5");
    step(0, 3, 0, 32, "R5");
    // R6: wrap at the top of the object bank
    step(1, 2, 8'hBF, 63, "R6");
    step(1, 3, 8'hE7, 63, "R6");
    step(0, 2, 0, 63, "R6");
    step(1, 3, 8'h3C, 32, "R6");
    // R10: same-cycle write invisible, full renderer scan
    step(1, 0, 8'h04, 2, "R10");
    step(1, 1, 8'hAB, 2, "R10");
    step(0, 1, 0, 2, "R10");
    for (int i = 0; i < 64; i++) step(0, i % 4, 0, i, "R10");
    step(0, 0, 0, 0, "R10");
    finish_run();
  end
endmodule